// File: doc/BRIEF.md
# Counted Loop Decrement-and-Branch Unit

This unit performs the execute step of a conditional counted-loop branch for a 32-bit data register. It takes the register contents, a 4-bit condition selector, the four processor status flags, the current program counter, the instruction length and a signed 16-bit displacement. From these it produces the register value to write back, a write enable, a branch-taken flag and the next program counter.

The condition is evaluated first. When it holds, the loop ends at once: the branch is not taken, the register is not written, and the next PC is the fall-through address. When it does not hold, the unit decrements only the low 16 bits of the register and keeps the upper half unchanged. If the new low half is all ones (-1), the loop is exhausted and execution falls through. Otherwise the branch goes to PC plus the sign-extended displacement. Selecting the "never" condition turns the instruction into a plain counted loop that runs 65536 times from a starting count of 0xFFFF.

The arithmetic is a single combinational step. Its result is captured in an output register whenever an input is presented while the downstream side is ready.

Top module: `loop_step_unit`

## Requirements
- R1: The 4-bit selector picks one of 16 conditions from the flags N, Z, V and C. The encodings are: 0 always, 1 never, 2 !C&!Z, 3 C|Z, 4 !C, 5 C, 6 !Z, 7 Z, 8 !V, 9 V, 10 !N, 11 N, 12 N==V, 13 N!=V, 14 (N==V)&!Z, 15 Z|(N!=V). The flags port carries N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. The write enable is 1 exactly when the selected condition is false.
- R2: When the condition is true, the result has write enable 0 and taken 0, the register value is returned unchanged, and the next PC is PC plus the instruction length.
- R3: When the condition is false, the returned bits [15:0] equal the input low half minus one, modulo 2^16. Bits [31:16] are returned unchanged, and write enable is 1.
- R4: When the condition is false and the decremented low half is 0xFFFF, taken is 0 and the next PC is PC plus the instruction length.
- R5: When the condition is false and the decremented low half is not 0xFFFF, taken is 1. The next PC is PC plus the displacement sign-extended to 32 bits, with bit 15 as the sign.
- R6: When the condition is true and the low half is 0, the returned register value keeps 0 in its low half, and the write enable stays 0.
- R7: Feeding the result back with the "never" condition, starting from low half 0xFFFF, gives 0xFFFF taken results and then one fall-through on the 65536th pass. The result of that pass is the starting upper half with low half 0xFFFF.
- R8: The output register loads on a rising edge where out_ready is 1, and out_valid then equals the in_valid of that edge. When out_ready is 0, every output holds its value.
- R9: While rst_n is low, out_valid, out_wr_en and out_taken are 0, and out_reg and out_next_pc are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| out_ready | input | 1 | Downstream can take a result; enables the output register |
| reg_val | input | 32 | Current loop register contents |
| cond_sel | input | 4 | Condition selector |
| flags | input | 4 | Status flags {N, Z, V, C} |
| pc | input | 32 | Program counter used as the branch base |
| insn_len | input | 4 | Instruction length added for fall-through |
| disp | input | 16 | Signed branch displacement |
| out_valid | output | 1 | Registered result is valid |
| out_reg | output | 32 | Register value to write back |
| out_wr_en | output | 1 | Write back out_reg |
| out_taken | output | 1 | The branch is taken |
| out_next_pc | output | 32 | Address of the next instruction |

## Verification
Every result is due one clock after the rising edge that captures its inputs. The bench drives inputs 2 ns after a rising edge. Its reference model updates its expected result on that same capturing edge, and the comparison runs at the following falling edge, so the DUT output and the expectation always describe the same capture. The counted-loop run feeds each result back on the cycle it appears, one pass per clock. Stall cycles are checked on the cycle after out_ready drops, against the held expectation.

// File: rtl/loop_step_pkg.sv
`timescale 1ns/1ps
package loop_step_pkg;

    typedef enum logic [3:0] {
        SEL_ALWAYS     = 4'd0,
        SEL_NEVER      = 4'd1,
        SEL_HIGHER     = 4'd2,
        SEL_LOWER_SAME = 4'd3,
        SEL_CARRY_CLR  = 4'd4,
        SEL_CARRY_SET  = 4'd5,
        SEL_NOT_EQUAL  = 4'd6,
        SEL_EQUAL      = 4'd7,
        SEL_OVF_CLR    = 4'd8,
        SEL_OVF_SET    = 4'd9,
        SEL_PLUS       = 4'd10,
        SEL_MINUS      = 4'd11,
        SEL_GE         = 4'd12,
        SEL_LT         = 4'd13,
        SEL_GT         = 4'd14,
        SEL_LE         = 4'd15
    } cond_sel_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } flags_t;

endpackage

// File: rtl/loop_cond_eval.sv
`timescale 1ns/1ps
module loop_cond_eval
    import loop_step_pkg::*;
(
    input  flags_t    flags,
    input  cond_sel_e sel,
    output logic      hit
);
    logic sign_ok;

    always_comb begin
        sign_ok = (flags.neg == flags.ovf);
        unique case (sel)
            SEL_ALWAYS:     hit = 1'b1;
            SEL_NEVER:      hit = 1'b0;
            SEL_HIGHER:     hit = !flags.carry && !flags.zero;
            SEL_LOWER_SAME: hit = flags.carry || flags.zero;
            SEL_CARRY_CLR:  hit = !flags.carry;
            SEL_CARRY_SET:  hit = flags.carry;
            SEL_NOT_EQUAL:  hit = !flags.zero;
            SEL_EQUAL:      hit = flags.zero;
            SEL_OVF_CLR:    hit = !flags.ovf;
            SEL_OVF_SET:    hit = flags.ovf;
            SEL_PLUS:       hit = !flags.neg;
            SEL_MINUS:      hit = flags.neg;
            SEL_GE:         hit = sign_ok;
            SEL_LT:         hit = !sign_ok;
            SEL_GT:         hit = sign_ok && !flags.zero;
            SEL_LE:         hit = flags.zero || !sign_ok;
            default:        hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/loop_count_step.sv
`timescale 1ns/1ps
module loop_count_step #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] stepped,
    output logic              exhausted
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] low_next;

    assign low_next  = value[CNT_W-1:0] - CNT_ONE;
    assign exhausted = &low_next;

    generate
        if (CNT_W < DATA_W) begin : g_split
            assign stepped = {value[DATA_W-1:CNT_W], low_next};
        end else begin : g_full
            assign stepped = low_next;
        end
    endgenerate
endmodule

// File: rtl/loop_target_gen.sv
`timescale 1ns/1ps
module loop_target_gen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int LEN_W  = 4
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [LEN_W-1:0]  insn_len,
    output logic [ADDR_W-1:0] branch_pc,
    output logic [ADDR_W-1:0] seq_pc
);
    localparam int EXT_W = ADDR_W - DISP_W;
    localparam int PAD_W = ADDR_W - LEN_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] len_ext;

    assign disp_ext  = {{EXT_W{disp[DISP_W-1]}}, disp};
    assign len_ext   = {{PAD_W{1'b0}}, insn_len};
    assign branch_pc = pc + disp_ext;
    assign seq_pc    = pc + len_ext;
endmodule

// File: rtl/loop_step_unit.sv
`timescale 1ns/1ps
module loop_step_unit
    import loop_step_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              out_ready,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [3:0]        cond_sel,
    input  logic [3:0]        flags,
    input  logic [ADDR_W-1:0] pc,
    input  logic [LEN_W-1:0]  insn_len,
    input  logic [DISP_W-1:0] disp,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_reg,
    output logic              out_wr_en,
    output logic              out_taken,
    output logic [ADDR_W-1:0] out_next_pc
);
    typedef struct packed {
        logic              valid;
        logic              wr;
        logic              taken;
        logic [DATA_W-1:0] value;
        logic [ADDR_W-1:0] npc;
    } result_t;

    localparam result_t RESULT_IDLE = '0;

    result_t           res_d, res_q;
    logic              cond_hit;
    logic              cnt_done;
    logic [DATA_W-1:0] cnt_value;
    logic [ADDR_W-1:0] branch_pc;
    logic [ADDR_W-1:0] seq_pc;

    loop_cond_eval u_cond (
        .flags (flags_t'(flags)),
        .sel   (cond_sel_e'(cond_sel)),
        .hit   (cond_hit)
    );

    loop_count_step #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_count (
        .value     (reg_val),
        .stepped   (cnt_value),
        .exhausted (cnt_done)
    );

    loop_target_gen #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .LEN_W  (LEN_W)
    ) u_target (
        .pc        (pc),
        .disp      (disp),
        .insn_len  (insn_len),
        .branch_pc (branch_pc),
        .seq_pc    (seq_pc)
    );

    always_comb begin
        res_d = res_q;
        if (out_ready) begin
            res_d.valid = in_valid;
            if (in_valid) begin
                if (cond_hit) begin
                    res_d.wr    = 1'b0;
                    res_d.taken = 1'b0;
                    res_d.value = reg_val;
                    res_d.npc   = seq_pc;
                end else begin
                    res_d.wr    = 1'b1;
                    res_d.value = cnt_value;
                    res_d.taken = !cnt_done;
                    res_d.npc   = cnt_done ? seq_pc : branch_pc;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= RESULT_IDLE;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign out_reg     = res_q.value;
    assign out_wr_en   = res_q.wr;
    assign out_taken   = res_q.taken;
    assign out_next_pc = res_q.npc;
endmodule

// File: rtl/loop_step_unit_chk.sv
`timescale 1ns/1ps
module loop_step_unit_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] reg_val,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_reg,
    input logic              out_wr_en,
    input logic              out_taken,
    input logic [ADDR_W-1:0] out_next_pc
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    p_capture_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |=> (out_valid == $past(in_valid)));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |=> ($stable(out_valid) && $stable(out_reg) && $stable(out_wr_en)
                        && $stable(out_taken) && $stable(out_next_pc)));

    p_low_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_ready) |=>
            (!out_wr_en || (out_reg[CNT_W-1:0] == $past(reg_val[CNT_W-1:0]) - ONE)));

    p_upper_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_ready) |=>
            (out_reg[DATA_W-1:CNT_W] == $past(reg_val[DATA_W-1:CNT_W])));

    p_untouched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_ready) |=> (out_wr_en || (out_reg == $past(reg_val))));

    p_hit_no_branch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wr_en) |-> !out_taken);

    p_wrap_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wr_en && (&out_reg[CNT_W-1:0])) |-> !out_taken);

    p_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wr_en && !(&out_reg[CNT_W-1:0])) |-> out_taken);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r9: assert (!out_valid && !out_wr_en && !out_taken
                                     && (out_reg == '0) && (out_next_pc == '0));
        end
    end
endmodule

bind loop_step_unit loop_step_unit_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_ready   (out_ready),
    .reg_val     (reg_val),
    .out_valid   (out_valid),
    .out_reg     (out_reg),
    .out_wr_en   (out_wr_en),
    .out_taken   (out_taken),
    .out_next_pc (out_next_pc)
);

// File: tb/loop_step_unit_bench.sv
`timescale 1ns/1ps
module loop_step_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, out_ready;
    logic [31:0] reg_val, pc;
    logic [3:0]  cond_sel, flags, insn_len;
    logic [15:0] disp;
    logic        out_valid, out_wr_en, out_taken;
    logic [31:0] out_reg, out_next_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    loop_step_unit u_loop_step_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
        .reg_val(reg_val), .cond_sel(cond_sel), .flags(flags), .pc(pc),
        .insn_len(insn_len), .disp(disp), .out_valid(out_valid), .out_reg(out_reg),
        .out_wr_en(out_wr_en), .out_taken(out_taken), .out_next_pc(out_next_pc)
    );

    typedef struct {
        bit          valid;
        bit          hit;
        bit          low_zero;
        bit          wr;
        bit          taken;
        logic [31:0] val;
        logic [31:0] npc;
    } ref_t;

    ref_t exp_q;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // R1 reference truth for each selector value
    function automatic bit cond_ref(input int sel, input logic [3:0] f);
        bit n = f[3], z = f[2], v = f[1], c = f[0];
        case (sel)
            0:  return 1;
            1:  return 0;
            2:  return (c == 0) && (z == 0);
            3:  return (c == 1) || (z == 1);
            4:  return c == 0;
            5:  return c == 1;
            6:  return z == 0;
            7:  return z == 1;
            8:  return v == 0;
            9:  return v == 1;
            10: return n == 0;
            11: return n == 1;
            12: return n == v;
            13: return n != v;
            14: return (n == v) && !z;
            default: return z || (n != v);
        endcase
    endfunction

    function automatic ref_t model(input logic [31:0] r, input int sel, input logic [3:0] f,
                                   input logic [31:0] p, input int len, input logic [15:0] d);
        ref_t m;
        int nl;
        int sd;
        m.valid    = 1;
        m.hit      = cond_ref(sel, f);
        m.low_zero = (r[15:0] == 16'h0000);
        if (m.hit) begin
            m.wr = 0; m.taken = 0; m.val = r; m.npc = p + len;
        end else begin
            nl = int'(r[15:0]) - 1;
            if (nl < 0) nl = 65535;
            m.wr    = 1;
            m.val   = {r[31:16], 16'(nl)};
            m.taken = (nl != 65535);
            sd      = (int'(d) >= 32768) ? int'(d) - 65536 : int'(d);
            m.npc   = m.taken ? p + sd : p + len;
        end
        return m;
    endfunction

    // Reference model: updates on the same edge that captures the inputs
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= '{default: 0};
        end else if (out_ready) begin
            if (in_valid) exp_q <= model(reg_val, int'(cond_sel), flags, pc, int'(insn_len), disp);
            else          exp_q.valid <= 1'b0;
        end
    end

    // Compare on every falling edge after reset
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk(out_valid == exp_q.valid, "R8 valid", 32'(out_valid), 32'(exp_q.valid));
            if (exp_q.valid) begin
                chk(out_wr_en == exp_q.wr, "R1 write enable", 32'(out_wr_en), 32'(exp_q.wr));
                if (exp_q.hit) begin
                    chk(out_reg == exp_q.val, exp_q.low_zero ? "R6 value" : "R2 value", out_reg, exp_q.val);
                    chk(out_taken == 1'b0, "R2 taken", 32'(out_taken), 32'd0);
                    chk(out_next_pc == exp_q.npc, "R2 next pc", out_next_pc, exp_q.npc);
                end else begin
                    chk(out_reg == exp_q.val, "R3 value", out_reg, exp_q.val);
                    chk(out_taken == exp_q.taken, exp_q.taken ? "R5 taken" : "R4 taken",
                        32'(out_taken), 32'(exp_q.taken));
                    chk(out_next_pc == exp_q.npc, exp_q.taken ? "R5 target" : "R4 next pc",
                        out_next_pc, exp_q.npc);
                end
            end
        end
    end

    function automatic logic [15:0] low_pick(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h0002;
            3: return 16'hFFFF;
            4: return 16'hFFFE;
            5: return 16'h8000;
            default: return 16'h7FFF;
        endcase
    endfunction

    function automatic logic [15:0] disp_pick(input int k);
        case (k % 4)
            0: return 16'h0004;
            1: return 16'hFFFC;
            2: return 16'h8000;
            default: return 16'h7FFE;
        endcase
    endfunction

    task automatic drive(input bit v, input bit rdy, input logic [31:0] r, input int sel,
                         input logic [3:0] f, input logic [31:0] p, input int len, input logic [15:0] d);
        @(posedge clk);
        #2;
        in_valid = v; out_ready = rdy; reg_val = r; cond_sel = 4'(sel);
        flags = f; pc = p; insn_len = 4'(len); disp = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int loops;
        int taken_cnt;
        rst_n = 1'b1;
        in_valid = 0; out_ready = 0; reg_val = '0; cond_sel = '0;
        flags = '0; pc = '0; insn_len = '0; disp = '0;
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R9: idle outputs during reset
        chk(out_valid == 0 && out_wr_en == 0 && out_taken == 0, "R9 flags", {29'd0, out_valid, out_wr_en, out_taken}, 32'd0);
        chk(out_reg == 0 && out_next_pc == 0, "R9 data", out_reg | out_next_pc, 32'd0);
        rst_n = 1'b1;

        // Directed R6: condition true with zero low half
        drive(1, 1, 32'h1234_0000, 0, 4'h0, 32'h0000_2000, 2, 16'h0010);
        drive(0, 1, 32'h0, 1, 4'h0, 32'h0, 2, 16'h0);
        chk(out_reg == 32'h1234_0000 && out_wr_en == 0, "R6 directed", out_reg, 32'h1234_0000);

        // Directed R8: stalled cycle keeps the previous result
        drive(1, 1, 32'h0000_0005, 1, 4'h0, 32'h0000_3000, 4, 16'hFFF0);
        drive(1, 0, 32'h0000_0009, 0, 4'h0, 32'h0000_4000, 2, 16'h0);
        drive(0, 0, 32'h0, 0, 4'h0, 32'h0, 2, 16'h0);
        chk(out_reg == 32'h0000_0004 && out_next_pc == 32'h0000_2FF0, "R8 hold", out_reg, 32'h0000_0004);

        // Sweep every selector, flag combination and boundary count
        for (int s = 0; s < 16; s++) begin
            for (int f = 0; f < 16; f++) begin
                for (int k = 0; k < 7; k++) begin
                    drive(((s * 3 + k) % 7) != 6, ((s + f + k) % 5) != 4,
                          {4'(s), 12'hA5A, low_pick(k)}, s, 4'(f),
                          32'h0001_0000 + 32'(f * 64), (k % 2 == 0) ? 2 : 4, disp_pick(k + f));
                end
            end
        end

        // R7: counted loop with the never condition, fed back each cycle
        drive(1, 1, 32'h0FFF_FFFF, 1, 4'h0, 32'h0000_8000, 4, 16'hFFFE);
        loops = 0;
        taken_cnt = 0;
        forever begin
            @(posedge clk);
            #2;
            loops++;
            if (!out_taken) break;
            taken_cnt++;
            reg_val = out_reg;
            if (loops > 70000) break;
        end
        chk(taken_cnt == 65535, "R7 taken count", 32'(taken_cnt), 32'd65535);
        chk(loops == 65536, "R7 pass count", 32'(loops), 32'd65536);
        chk(out_reg == 32'h0FFF_FFFF, "R7 final value", out_reg, 32'h0FFF_FFFF);
        chk(out_next_pc == 32'h0000_8004, "R7 fall-through", out_next_pc, 32'h0000_8004);

        in_valid = 0;
        repeat (2) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule